// File: doc/BRIEF.md
# HDB3 Line Decoder with Alarm Detection

This block turns a dual-rail HDB3 symbol stream back into a single NRZ bit stream and watches the line for three fault conditions. On each decoder clock it takes one symbol from a positive rail and a negative rail. A mark is normally decoded as a one. A mark with the same polarity as the mark before it is a substitution violation: it is decoded as a zero. The balancing mark that may have opened the same four-symbol substitution group is also turned back into a zero. The decoded stream leaves the block after a fixed pipeline delay.

There are three alarms. A one-cycle error pulse flags two violations in a row with the same polarity. A level alarm flags a long run of zero symbols on both rails. An all-ones alarm counts the decoded zeros inside a framing window that an external control input defines. This alarm is resolved each time that input makes a low pulse. A loopback select replaces the line rails with the rails of the local encoder, so the terminal can be tested. Everything runs in the decoder clock domain. The local encoder rails are assumed to be already valid in that domain.

Top module: `hdb3_rx_alarms`

## Requirements
- R1: With `loop_en` high, the symbol comes from `enc_p`/`enc_n` and `line_p`/`line_n` have no effect. With `loop_en` low, the symbol comes from the line rails and the encoder rails have no effect.
- R2: The symbol taken at a clock edge is a positive mark when the positive rail is 1, a negative mark when only the negative rail is 1, and a zero symbol when both rails are 0. Both rails high counts as a positive mark.
- R3: The NRZ value for the symbol taken at rising edge k appears on `nrz_out` just after rising edge k+5 and holds for one clock period.
- R4: A mark decodes to 1, except when it is a violation (same polarity as the previous mark). A violation decodes to 0 and also forces to 0 the symbol taken three edges earlier. After reset the previous-mark polarity is negative, so a negative first mark is a violation.
- R5: `dv_err` is high for exactly the period after edge k+1 when the symbol taken at edge k is a violation with the same polarity as the previous violation. The first violation after reset never raises `dv_err`.
- R6: `los_alarm` is high after edge k+1 when the symbol at edge k ends a run of at least 11 consecutive zero symbols. A mark taken at edge m drives `los_alarm` low after edge m+1.
- R7: At each edge where `ais_win` is sampled high, a decoded-zero counter adds one if `nrz_out` was 0 just before that edge. The counter saturates at 3. While `ais_win` is low the counter is held at zero.
- R8: At an edge where `ais_win` is sampled low after being sampled high at the previous edge, `ais_alarm` becomes 1 if fewer than 3 decoded zeros were counted since the previous such edge, and 0 otherwise. `ais_alarm` changes at no other edge.
- R9: While `rst_n` is low, `nrz_out`, `dv_err`, `los_alarm` and `ais_alarm` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Decoder clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| line_p | input | 1 | Positive rail from the line |
| line_n | input | 1 | Negative rail from the line |
| enc_p | input | 1 | Positive rail from the local encoder |
| enc_n | input | 1 | Negative rail from the local encoder |
| loop_en | input | 1 | High selects the encoder rails instead of the line rails |
| ais_win | input | 1 | Framing window: high enables zero counting, a low pulse resolves the all-ones alarm |
| nrz_out | output | 1 | Decoded NRZ data |
| dv_err | output | 1 | One-cycle pulse on a same-polarity double violation |
| los_alarm | output | 1 | Loss-of-input alarm after a long zero run |
| ais_alarm | output | 1 | All-ones alarm, updated on each window low pulse |

## Verification
Several internal faults show up at the ports. A stale last-mark polarity turns a data mark into a zero on `nrz_out` five cycles later. A wrong last-violation polarity either drops a `dv_err` pulse or creates one one cycle after the offending symbol. A delay-line tap off by one position leaves a balancing mark decoded as a one, or clears a genuine data bit, and either error reaches `nrz_out` within five cycles. Counter faults in the zero-run or window logic shift the `los_alarm` edge by whole cycles, or flip `ais_alarm` at the next window low pulse. The bench compares all four outputs against a behavioural model every clock, so each of these faults appears as soon as the first affected output cycle is reached.

// File: rtl/hdb3_rx_pkg.sv
package hdb3_rx_pkg;

  // Length of one HDB3 substitution group (B00V / 000V)
  localparam int SUB_LEN = 4;

  typedef enum logic [1:0] {
    SYM_ZERO = 2'd0,
    SYM_POS  = 2'd1,
    SYM_NEG  = 2'd2
  } sym_e;

  // Positive rail wins when both rails are asserted
  function automatic sym_e classify(input logic p, input logic n);
    sym_e s;
    if (p)      s = SYM_POS;
    else if (n) s = SYM_NEG;
    else        s = SYM_ZERO;
    return s;
  endfunction

endpackage

// File: rtl/hdb3_rx_front.sv
module hdb3_rx_front
  import hdb3_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic line_p,
  input  logic line_n,
  input  logic enc_p,
  input  logic enc_n,
  input  logic loop_en,
  output sym_e sym_now,
  output sym_e sym_q
);

  logic sel_p;
  logic sel_n;

  // Rail source select and symbol classification
  always_comb begin
    sel_p   = loop_en ? enc_p : line_p;
    sel_n   = loop_en ? enc_n : line_n;
    sym_now = classify(sel_p, sel_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_q <= SYM_ZERO;
    end else begin
      sym_q <= sym_now;
    end
  end

endmodule

// File: rtl/hdb3_rx_viol.sv
module hdb3_rx_viol
  import hdb3_rx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  sym_e sym_q,
  output logic nrz_q,
  output logic dv_q
);

  localparam int DLY  = SUB_LEN;      // delay-line taps
  localparam int BACK = SUB_LEN - 1;  // distance to the balancing mark

  logic           is_mark;
  logic           pol;
  logic           is_viol;
  logic           dbl_viol;
  logic           mark_en;
  logic           viol_en;
  logic           last_pol_q;
  logic           vpol_q;
  logic           vseen_q;
  logic [DLY-1:0] dl_q;
  logic [DLY-1:0] dl_d;

  // Next-state: classify the registered symbol against tracked polarity
  always_comb begin
    is_mark  = (sym_q != SYM_ZERO);
    pol      = (sym_q == SYM_POS);
    is_viol  = is_mark && (pol == last_pol_q);
    dbl_viol = is_viol && vseen_q && (pol == vpol_q);
    mark_en  = is_mark;
    viol_en  = is_viol;
  end

  // Delay line: a violation clears itself and the tap that will become
  // the slot BACK symbols earlier
  assign dl_d[0] = is_mark & ~is_viol;
  for (genvar i = 1; i < DLY; i++) begin : g_tap
    if (i == BACK) begin : g_clr
      assign dl_d[i] = dl_q[i-1] & ~is_viol;
    end else begin : g_pass
      assign dl_d[i] = dl_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_pol_q <= 1'b0;
    end else if (mark_en) begin
      last_pol_q <= pol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vpol_q  <= 1'b0;
      vseen_q <= 1'b0;
    end else if (viol_en) begin
      vpol_q  <= pol;
      vseen_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dl_q  <= '0;
      nrz_q <= 1'b0;
      dv_q  <= 1'b0;
    end else begin
      dl_q  <= dl_d;
      nrz_q <= dl_q[DLY-1];
      dv_q  <= dbl_viol;
    end
  end

endmodule

// File: rtl/hdb3_rx_los.sv
module hdb3_rx_los
  import hdb3_rx_pkg::*;
#(
  parameter int LOS_ZEROS = 11
) (
  input  logic clk,
  input  logic rst_n,
  input  sym_e sym_now,
  output logic los_q
);

  localparam int CW = $clog2(LOS_ZEROS + 1);
  localparam logic [CW-1:0] LIMIT = CW'(LOS_ZEROS);

  logic [CW-1:0] zcnt_q;
  logic [CW-1:0] zcnt_d;
  logic          cnt_en;
  logic          los_d;

  always_comb begin
    cnt_en = 1'b1;
    if (sym_now != SYM_ZERO)  zcnt_d = '0;
    else if (zcnt_q == LIMIT) zcnt_d = zcnt_q;
    else                      zcnt_d = zcnt_q + 1'b1;
    los_d = (zcnt_q == LIMIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      zcnt_q <= '0;
      los_q  <= 1'b0;
    end else if (cnt_en) begin
      zcnt_q <= zcnt_d;
      los_q  <= los_d;
    end
  end

endmodule

// File: rtl/hdb3_rx_ais.sv
module hdb3_rx_ais #(
  parameter int MIN_ZEROS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic win_i,
  input  logic nrz_i,
  output logic ais_q
);

  localparam int CW = $clog2(MIN_ZEROS + 1);
  localparam logic [CW-1:0] SAT = CW'(MIN_ZEROS);

  logic          win_q;
  logic          fall;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          ais_d;
  logic          ais_en;

  always_comb begin
    fall = win_q & ~win_i;
    if (fall || !win_i)            cnt_d = '0;
    else if (!nrz_i && cnt_q != SAT) cnt_d = cnt_q + 1'b1;
    else                           cnt_d = cnt_q;
    ais_d  = (cnt_q < SAT);
    ais_en = fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      win_q <= win_i;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ais_q <= 1'b0;
    end else if (ais_en) begin
      ais_q <= ais_d;
    end
  end

endmodule

// File: rtl/hdb3_rx_alarms.sv
module hdb3_rx_alarms
  import hdb3_rx_pkg::*;
#(
  parameter int LOS_ZEROS     = 11,
  parameter int AIS_MIN_ZEROS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_p,
  input  logic line_n,
  input  logic enc_p,
  input  logic enc_n,
  input  logic loop_en,
  input  logic ais_win,
  output logic nrz_out,
  output logic dv_err,
  output logic los_alarm,
  output logic ais_alarm
);

  sym_e sym_now;
  sym_e sym_q;

  hdb3_rx_front u_front (
    .clk     (clk),
    .rst_n   (rst_n),
    .line_p  (line_p),
    .line_n  (line_n),
    .enc_p   (enc_p),
    .enc_n   (enc_n),
    .loop_en (loop_en),
    .sym_now (sym_now),
    .sym_q   (sym_q)
  );

  hdb3_rx_viol u_viol (
    .clk   (clk),
    .rst_n (rst_n),
    .sym_q (sym_q),
    .nrz_q (nrz_out),
    .dv_q  (dv_err)
  );

  hdb3_rx_los #(.LOS_ZEROS(LOS_ZEROS)) u_los (
    .clk     (clk),
    .rst_n   (rst_n),
    .sym_now (sym_now),
    .los_q   (los_alarm)
  );

  hdb3_rx_ais #(.MIN_ZEROS(AIS_MIN_ZEROS)) u_ais (
    .clk   (clk),
    .rst_n (rst_n),
    .win_i (ais_win),
    .nrz_i (nrz_out),
    .ais_q (ais_alarm)
  );

endmodule

// File: rtl/hdb3_rx_alarms_chk.sv
module hdb3_rx_alarms_chk (
  input logic clk,
  input logic rst_n,
  input logic line_p,
  input logic line_n,
  input logic enc_p,
  input logic enc_n,
  input logic loop_en,
  input logic ais_win,
  input logic nrz_out,
  input logic dv_err,
  input logic los_alarm,
  input logic ais_alarm
);

  logic mark_in;
  assign mark_in = loop_en ? (enc_p | enc_n) : (line_p | line_n);

  AST_NRZ_NEEDS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    nrz_out |-> $past(mark_in, 6)); // R3

  AST_DV_NEEDS_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    dv_err |-> $past(mark_in, 2)); // R5

  AST_LOS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    mark_in |=> ##1 !los_alarm); // R6

  AST_LOS_RISE_ON_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(los_alarm) |-> !$past(mark_in, 2)); // R6

  AST_AIS_MOVES_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ais_alarm) |-> (!$past(ais_win) && $past(ais_win, 2))); // R8

endmodule

bind hdb3_rx_alarms hdb3_rx_alarms_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .line_p    (line_p),
  .line_n    (line_n),
  .enc_p     (enc_p),
  .enc_n     (enc_n),
  .loop_en   (loop_en),
  .ais_win   (ais_win),
  .nrz_out   (nrz_out),
  .dv_err    (dv_err),
  .los_alarm (los_alarm),
  .ais_alarm (ais_alarm)
);

// File: tb/hdb3_rx_alarms_bench.sv
module hdb3_rx_alarms_bench;

  localparam int LOS  = 11;
  localparam int MINZ = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_p = 1'b0, line_n = 1'b0, enc_p = 1'b0, enc_n = 1'b0;
  logic loop_en = 1'b0, ais_win = 1'b1;
  logic nrz_out, dv_err, los_alarm, ais_alarm;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  hdb3_rx_alarms u_hdb3_rx_alarms (
    .clk(clk), .rst_n(rst_n),
    .line_p(line_p), .line_n(line_n), .enc_p(enc_p), .enc_n(enc_n),
    .loop_en(loop_en), .ais_win(ais_win),
    .nrz_out(nrz_out), .dv_err(dv_err), .los_alarm(los_alarm), .ais_alarm(ais_alarm)
  );

  // ---------------- reference model ----------------
  bit m_q[$];
  bit m_lastm, m_lastv, m_vseen, m_pend_dv, m_win_q;
  int m_run, m_zc;
  bit x_nrz, x_dv, x_los, x_ais;
  bit model_on = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_q = {};
      repeat (5) m_q.push_back(1'b0);
      m_lastm = 0; m_lastv = 0; m_vseen = 0; m_pend_dv = 0; m_win_q = 0;
      m_run = 0; m_zc = 0;
      x_nrz = 0; x_dv = 0; x_los = 0; x_ais = 0;
    end else begin
      bit p, n, mark, pol, viol, nrz_old;
      p = loop_en ? enc_p : line_p;
      n = loop_en ? enc_n : line_n;
      nrz_old = x_nrz;
      x_nrz = m_q.pop_front();
      x_dv  = m_pend_dv;
      x_los = (m_run >= LOS);
      if (m_win_q && !ais_win) begin
        x_ais = (m_zc < MINZ);
        m_zc = 0;
      end else if (!ais_win) begin
        m_zc = 0;
      end else if (!nrz_old && m_zc < MINZ) begin
        m_zc++;
      end
      m_win_q = ais_win;
      mark = p | n;
      pol  = p;
      viol = mark && (pol == m_lastm);
      m_pend_dv = viol && m_vseen && (pol == m_lastv);
      m_q.push_back(mark && !viol);
      if (viol) m_q[1] = 1'b0;
      if (mark) m_lastm = pol;
      if (viol) begin m_lastv = pol; m_vseen = 1'b1; end
      if (mark) m_run = 0;
      else if (m_run < LOS) m_run++;
      model_on = 1'b1;
    end
  end

  int seen_dv = 0, seen_los = 0;

  task automatic chk(input string tag, input bit act, input bit exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && model_on && !finished) begin
      chk("R3 R4 R1 R2 nrz_out", nrz_out, x_nrz);
      chk("R5 dv_err", dv_err, x_dv);
      chk("R6 los_alarm", los_alarm, x_los);
      chk("R7 R8 ais_alarm", ais_alarm, x_ais);
      if (dv_err) seen_dv++;
      if (los_alarm) seen_los++;
    end
  end

  // ---------------- reference HDB3 encoder ----------------
  bit sp[$], sn[$];
  bit e_lastm = 1'b0, e_lastv = 1'b1;
  int e_zrun = 0;

  task automatic enc_push(input bit b);
    int len;
    if (b) begin
      e_lastm = ~e_lastm;
      sp.push_back(e_lastm); sn.push_back(~e_lastm);
      e_zrun = 0;
    end else begin
      sp.push_back(1'b0); sn.push_back(1'b0);
      e_zrun++;
      if (e_zrun == 4) begin
        len = sp.size();
        if (e_lastm == e_lastv) begin
          e_lastm = ~e_lastm;
          sp[len-4] = e_lastm; sn[len-4] = ~e_lastm;
        end
        sp[len-1] = e_lastm; sn[len-1] = ~e_lastm;
        e_lastv = e_lastm;
        e_zrun = 0;
      end
    end
  endtask

  int cyc = 0;

  task automatic play(input bit lp, input int win_per);
    while (sp.size() > 0) begin
      bit pb, nb;
      @(negedge clk);
      pb = sp.pop_front(); nb = sn.pop_front();
      loop_en = lp;
      if (lp) begin
        enc_p = pb; enc_n = nb;
        line_p = ($urandom_range(0, 1) == 1); line_n = ($urandom_range(0, 1) == 1);
      end else begin
        line_p = pb; line_n = nb;
        enc_p = ($urandom_range(0, 1) == 1); enc_n = ($urandom_range(0, 1) == 1);
      end
      ais_win = ((cyc % win_per) >= 2);
      cyc++;
    end
  endtask

  task automatic send_raw(input bit p, input bit n);
    @(negedge clk);
    loop_en = 1'b0; line_p = p; line_n = n; ais_win = 1'b1;
    enc_p = ($urandom_range(0, 1) == 1); enc_n = ($urandom_range(0, 1) == 1);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    repeat (4) @(negedge clk);
    // R9: reset state
    chk("R9 nrz_out reset", nrz_out, 1'b0);
    chk("R9 dv_err reset", dv_err, 1'b0);
    chk("R9 los_alarm reset", los_alarm, 1'b0);
    chk("R9 ais_alarm reset", ais_alarm, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // R3 R4 R7 R8: zero-heavy random data on the line
    for (int i = 0; i < 600; i++) enc_push($urandom_range(0, 3) == 0);
    play(1'b0, 40);
    // R4: dense random data
    for (int i = 0; i < 400; i++) enc_push($urandom_range(0, 1) == 1);
    play(1'b0, 37);
    // R8: all ones sets the all-ones alarm
    for (int i = 0; i < 300; i++) enc_push(1'b1);
    play(1'b0, 50);
    chk("R8 ais set after all ones", ais_alarm, 1'b1);
    // R8: zero-rich data clears it again
    for (int i = 0; i < 300; i++) enc_push($urandom_range(0, 2) == 0);
    play(1'b0, 50);
    chk("R8 ais cleared after zeros", ais_alarm, 1'b0);
    // R1: loopback with junk on the line rails
    for (int i = 0; i < 500; i++) enc_push($urandom_range(0, 3) != 0);
    play(1'b1, 45);
    // R6: long zero run, then a mark, then another run
    for (int i = 0; i < 30; i++) send_raw(1'b0, 1'b0);
    send_raw(1'b1, 1'b0);
    for (int i = 0; i < 9; i++) send_raw(1'b0, 1'b0);
    send_raw(1'b0, 1'b1);
    for (int i = 0; i < 20; i++) send_raw(1'b0, 1'b0);
    // R5 R2: same-polarity violations, including a both-rails symbol
    send_raw(1'b1, 1'b0); send_raw(1'b0, 1'b0); send_raw(1'b1, 1'b0);
    send_raw(1'b0, 1'b0); send_raw(1'b1, 1'b1); send_raw(1'b0, 1'b0);
    send_raw(1'b0, 1'b1); send_raw(1'b0, 1'b1); send_raw(1'b0, 1'b0);
    send_raw(1'b0, 1'b1);
    for (int i = 0; i < 10; i++) send_raw(1'b0, 1'b0);

    total++;
    if (seen_dv == 0) begin bad++; $display("FAIL R5 dv pulses actual=%0d expected=>0", seen_dv); end
    total++;
    if (seen_los == 0) begin bad++; $display("FAIL R6 los cycles actual=%0d expected=>0", seen_los); end

    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule